// File: doc/BRIEF.md
# Edge-Event GPIO Controller

This block is a register-mapped general-purpose I/O controller for 32 lines. Software reaches it through a plain single-cycle bus: a write lands on the next clock edge, and read data appears combinationally in the same cycle as the read request. Each line can be an input or an output. An output can drive both levels or act as an open-drain pull-down. An input is resynchronized to the clock, and its value can be seen in the data register only while that line's input buffer is enabled.

Transitions on the synchronized inputs are recorded in a sticky event register. Each line can record falling edges only, or both edges. Software clears pending events by writing ones. The single interrupt output is high while any pending event is also unmasked.

Throughout the register file, line n sits at bit 31−n. Pin-side vectors are indexed by line number, so pinIn[n] is line n.

Top module: `gpio_edge_unit`

## Requirements
- R1: After reset every register reads 0, pinOe is all zero, and irq is low.
- R2: Line n corresponds to register bit 31−n in every register. For example, writing data value 0x80000000 with direction 0x80000000 drives pinOut[0] high.
- R3: A direction bit of 1 makes the line an output, with pinOe[n] high and pinOut[n] equal to its latch bit. A direction bit of 0 keeps pinOe[n] low.
- R4: When the open-drain bit of an output line is 1, the line drives low (pinOe high) for a latch value of 0 and is released (pinOe low) for a latch value of 1.
- R5: A read of the data register (offset 0x08) returns the latch bit for output lines and the gated synchronized pin for input lines. A write to it changes only the latch.
- R6: The data bit of an input line reads 0 while its input-buffer-enable bit (offset 0x18) is 0, whatever the pin level.
- R7: An edge-control bit (offset 0x14) of 1 records only falling edges on that line. A bit of 0 records both rising and falling edges in the event register (offset 0x0C).
- R8: Writing 1 to an event bit clears it, and bits written 0 are unchanged. Event bits fall only on such a write.
- R9: If an edge is detected on a line in the same cycle as a clearing write to its event bit, the bit stays set.
- R10: irq is high exactly when some bit of (event AND mask) is 1, where the mask is at offset 0x10 and 1 enables the line.
- R11: Reads of offsets other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18 (including misaligned ones) return 0, and writes to them change nothing.
- R12: Suppose a pin changes just after clock edge k. The new value reads in the data register from edge k+2, and the resulting event bit is set at edge k+3, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access request in this cycle |
| busWr | input | 1 | 1 for write, 0 for read |
| busAddr | input | 5 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the request cycle |
| pinIn | input | 32 | Pin levels, index = line number |
| pinOe | output | 32 | Output enable per line |
| pinOut | output | 32 | Driven value per line |
| irq | output | 1 | Interrupt, OR of unmasked pending events |

## Verification
The hardest case to reach is the collision in which a clearing write to the event register commits on the very edge where a new transition is being detected on the same line. The stimulus changes a pin right after an edge, waits exactly one bus cycle, and then issues the clearing write so that it lands on the third edge. A read-back then shows the bit still set. The same cycle counting drives the latency checks. They read the data register one cycle too early and then read the event register on the edge before and on the edge after it becomes set, so an extra or a missing synchronizer stage is exposed.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  // Byte offsets of the register file (software-visible map)
  localparam logic [7:0] OFF_DIR = 8'h00;
  localparam logic [7:0] OFF_ODR = 8'h04;
  localparam logic [7:0] OFF_DAT = 8'h08;
  localparam logic [7:0] OFF_EVT = 8'h0C;
  localparam logic [7:0] OFF_MSK = 8'h10;
  localparam logic [7:0] OFF_EDG = 8'h14;
  localparam logic [7:0] OFF_IBE = 8'h18;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_ODR,
    SEL_DAT,
    SEL_EVT,
    SEL_MSK,
    SEL_EDG,
    SEL_IBE
  } regSel_e;

  // Strobes from the decode to the datapath
  typedef struct packed {
    logic    wrDir;
    logic    wrOdr;
    logic    wrDat;
    logic    wrEvt;
    logic    wrMsk;
    logic    wrEdg;
    logic    wrIbe;
    regSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strb
);

  regSel_e hitSel;

  // Full-address match: misaligned or out-of-map offsets select nothing
  always_comb begin
    case (busAddr)
      ADDR_W'(OFF_DIR): hitSel = SEL_DIR;
      ADDR_W'(OFF_ODR): hitSel = SEL_ODR;
      ADDR_W'(OFF_DAT): hitSel = SEL_DAT;
      ADDR_W'(OFF_EVT): hitSel = SEL_EVT;
      ADDR_W'(OFF_MSK): hitSel = SEL_MSK;
      ADDR_W'(OFF_EDG): hitSel = SEL_EDG;
      ADDR_W'(OFF_IBE): hitSel = SEL_IBE;
      default:          hitSel = SEL_NONE;
    endcase
  end

  logic doWr;
  logic doRd;
  assign doWr = busSel && busWr;
  assign doRd = busSel && !busWr;

  always_comb begin
    strb       = '0;
    strb.wrDir = doWr && (hitSel == SEL_DIR);
    strb.wrOdr = doWr && (hitSel == SEL_ODR);
    strb.wrDat = doWr && (hitSel == SEL_DAT);
    strb.wrEvt = doWr && (hitSel == SEL_EVT);
    strb.wrMsk = doWr && (hitSel == SEL_MSK);
    strb.wrEdg = doWr && (hitSel == SEL_EDG);
    strb.wrIbe = doWr && (hitSel == SEL_IBE);
    strb.rdSel = doRd ? hitSel : SEL_NONE;
  end

endmodule

// File: rtl/gpio_edge_dpath.sv
module gpio_edge_dpath
  import gpio_edge_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobe_t  strb,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] pinIn,
  output logic [N-1:0] pinOe,
  output logic [N-1:0] pinOut,
  output logic [N-1:0] rdata,
  output logic         irq
);

  logic [N-1:0] dirReg, odrReg, latReg, evtReg, mskReg, edgReg, ibeReg;
  logic [N-1:0] syncA, syncB, prevS;
  logic [N-1:0] pinBits, oeBits;

  // Line n <-> register bit N-1-n
  for (genvar n = 0; n < N; n++) begin : g_map
    assign pinBits[N-1-n] = pinIn[n];
    assign pinOe[n]       = oeBits[N-1-n];
    assign pinOut[n]      = latReg[N-1-n];
  end

  // Open-drain lines let go when their latch is high
  assign oeBits = dirReg & ~(odrReg & latReg);

  logic [N-1:0] riseBits, fallBits, hitBits, clrBits;
  assign riseBits = syncB & ~prevS;
  assign fallBits = ~syncB & prevS;
  assign hitBits  = fallBits | (riseBits & ~edgReg);
  assign clrBits  = strb.wrEvt ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevS <= '0;
    end else begin
      syncA <= pinBits;
      syncB <= syncA;
      prevS <= syncB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg <= '0;
      odrReg <= '0;
      latReg <= '0;
      mskReg <= '0;
      edgReg <= '0;
      ibeReg <= '0;
    end else begin
      if (strb.wrDir) dirReg <= wdata;
      if (strb.wrOdr) odrReg <= wdata;
      if (strb.wrDat) latReg <= wdata;
      if (strb.wrMsk) mskReg <= wdata;
      if (strb.wrEdg) edgReg <= wdata;
      if (strb.wrIbe) ibeReg <= wdata;
    end
  end

  // A new edge wins over a clear aimed at the same bit
  always_ff @(posedge clk) begin
    if (!rstN) evtReg <= '0;
    else       evtReg <= (evtReg & ~clrBits) | hitBits;
  end

  logic [N-1:0] dataView;
  assign dataView = (latReg & dirReg) | (syncB & ibeReg & ~dirReg);

  always_comb begin
    case (strb.rdSel)
      SEL_DIR: rdata = dirReg;
      SEL_ODR: rdata = odrReg;
      SEL_DAT: rdata = dataView;
      SEL_EVT: rdata = evtReg;
      SEL_MSK: rdata = mskReg;
      SEL_EDG: rdata = edgReg;
      SEL_IBE: rdata = ibeReg;
      default: rdata = '0;
    endcase
  end

  assign irq = |(evtReg & mskReg);

endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit
  import gpio_edge_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [N-1:0]      busWdata,
  output logic [N-1:0]      busRdata,
  input  logic [N-1:0]      pinIn,
  output logic [N-1:0]      pinOe,
  output logic [N-1:0]      pinOut,
  output logic              irq
);

  ctrlStrobe_t strb;

  gpio_edge_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strb   (strb)
  );

  gpio_edge_dpath #(.N(N)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wdata (busWdata),
    .pinIn (pinIn),
    .pinOe (pinOe),
    .pinOut(pinOut),
    .rdata (busRdata),
    .irq   (irq)
  );

endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk
  import gpio_edge_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [N-1:0]      busRdata,
  input logic [N-1:0]      pinOe,
  input logic              irq,
  input logic [N-1:0]      dirReg,
  input logic [N-1:0]      odrReg,
  input logic [N-1:0]      latReg,
  input logic [N-1:0]      evtReg,
  input logic [N-1:0]      mskReg,
  input logic [N-1:0]      ibeReg
);

  function automatic logic [N-1:0] flip(input logic [N-1:0] v);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = v[N-1-i];
    return r;
  endfunction

  logic rdReq, evtWr, unmapped;
  assign rdReq    = busSel && !busWr;
  assign evtWr    = busSel && busWr && (busAddr == ADDR_W'(OFF_EVT));
  assign unmapped = (busAddr[1:0] != 2'b00) || (busAddr > ADDR_W'(OFF_IBE));

  // R3
  input_line_never_driven_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe & ~flip(dirReg)) == '0);

  // R4
  open_drain_high_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe & flip(odrReg & latReg)) == '0);

  // R6
  gated_input_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && busAddr == ADDR_W'(OFF_DAT)) |-> ((busRdata & ~dirReg & ~ibeReg) == '0));

  // R8
  event_falls_only_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((($past(evtReg) & ~evtReg) != '0)) |-> $past(evtWr));

  // R10
  masked_irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mskReg == '0 || evtReg == '0) |-> !irq);

  // R11
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && unmapped) |-> (busRdata == '0));

endmodule

bind gpio_edge_unit gpio_edge_chk #(.N(N), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWr   (busWr),
  .busAddr (busAddr),
  .busRdata(busRdata),
  .pinOe   (pinOe),
  .irq     (irq),
  .dirReg  (u_dp.dirReg),
  .odrReg  (u_dp.odrReg),
  .latReg  (u_dp.latReg),
  .evtReg  (u_dp.evtReg),
  .mskReg  (u_dp.mskReg),
  .ibeReg  (u_dp.ibeReg)
);

// File: tb/gpio_edge_unit_tb.sv
module gpio_edge_unit_tb;

  localparam logic [4:0] A_DIR = 5'h00, A_ODR = 5'h04, A_DAT = 5'h08, A_EVT = 5'h0C,
                         A_MSK = 5'h10, A_EDG = 5'h14, A_IBE = 5'h18;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busSel, busWr;
  logic [4:0]  busAddr;
  logic [31:0] busWdata, busRdata, pinIn, pinOe, pinOut;
  logic        irq;

  always #10 clk = ~clk;  // 50 MHz

  gpio_edge_unit u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .pinOe(pinOe),
    .pinOut(pinOut), .irq(irq)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    nChecks = 0;
  int    nFails  = 0;
  bit    done    = 0;

  function automatic logic [31:0] lb(input int n);
    return 32'h8000_0000 >> n;
  endfunction

  // Driver tasks: each drives one bus cycle just after a rising edge
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      busSel = 1'b0; busWr = 1'b0;
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #2;
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic setPin(input logic [31:0] v);
    @(posedge clk); #2;
    busSel = 1'b0; busWr = 1'b0; pinIn = v;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
    @(negedge clk);
    nChecks++;
    if (act !== e) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, e);
    end
  endtask

  // Monitor: pops the expected item for every read cycle
  always @(negedge clk) begin
    if (rstN && busSel && !busWr) begin
      nChecks++;
      if (q.size() == 0) begin
        nFails++;
        $display("FAIL unexpected read actual=%h expected=none", busRdata);
      end else begin
        item_t it;
        it = q.pop_front();
        if (busRdata !== it.exp) begin
          nFails++;
          $display("FAIL %s actual=%h expected=%h", it.tag, busRdata, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog R1..all actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; busSel = 1'b0; busWr = 1'b0; busAddr = '0; busWdata = '0; pinIn = '0;
    repeat (4) @(posedge clk);
    #2 rstN = 1'b1;

    // R1 reset state
    chk(pinOe, 32'h0, "R1 pinOe");
    chk({31'h0, irq}, 32'h0, "R1 irq");
    rd(A_DIR, 0, "R1 dir"); rd(A_ODR, 0, "R1 odr"); rd(A_DAT, 0, "R1 dat");
    rd(A_EVT, 0, "R1 evt"); rd(A_MSK, 0, "R1 msk"); rd(A_EDG, 0, "R1 edg");
    rd(A_IBE, 0, "R1 ibe");

    // R2 / R3: lines 0 and 5 as outputs, line 0 latched high
    wr(A_DIR, lb(0) | lb(5));
    wr(A_DAT, lb(0));
    idle(1);
    chk(pinOe, 32'h21, "R3 pinOe");
    chk(pinOut, 32'h1, "R2 pinOut");
    rd(A_DAT, lb(0), "R5 dat outputs");

    // R4 open drain
    wr(A_ODR, lb(0) | lb(5));
    idle(1);
    chk(pinOe, 32'h20, "R4 od pinOe");

    // R6 gating, R5 mixed read
    setPin(32'h100);
    idle(3);
    rd(A_DAT, lb(0), "R6 ibe off");
    wr(A_DAT, 32'hFFFF_FFFF);
    wr(A_IBE, 32'hFFFF_FFFF);
    rd(A_DAT, lb(0) | lb(5) | lb(8), "R5 dat mix");
    idle(1);
    chk(pinOe, 32'h0, "R4 od released");

    // R8 clear all
    wr(A_EVT, 32'hFFFF_FFFF);
    rd(A_EVT, 0, "R8 clear all");

    // R12 latency on line 3
    setPin(32'h108);
    rd(A_DAT, lb(0) | lb(5) | lb(8), "R12 dat not yet");
    rd(A_EVT, 0, "R12 evt not yet");
    rd(A_EVT, lb(3), "R12 evt set");
    rd(A_DAT, lb(0) | lb(3) | lb(5) | lb(8), "R12 dat new");

    // R7 edge selection
    wr(A_EDG, lb(4));
    wr(A_EVT, 32'hFFFF_FFFF);
    setPin(32'h118);
    idle(4);
    rd(A_EVT, 0, "R7 rise ignored");
    setPin(32'h108);
    idle(4);
    rd(A_EVT, lb(4), "R7 fall recorded");
    setPin(32'h100);
    idle(4);
    rd(A_EVT, lb(3) | lb(4), "R7 both-edge fall");

    // R10 interrupt / R8 partial clear
    idle(1);
    chk({31'h0, irq}, 32'h0, "R10 all masked");
    wr(A_MSK, lb(5));
    idle(1);
    chk({31'h0, irq}, 32'h0, "R10 other line masked");
    wr(A_MSK, lb(4));
    idle(1);
    chk({31'h0, irq}, 32'h1, "R10 unmasked");
    wr(A_EVT, lb(3));
    rd(A_EVT, lb(4), "R8 partial clear");
    chk({31'h0, irq}, 32'h1, "R10 still pending");
    wr(A_EVT, lb(4));
    idle(1);
    chk({31'h0, irq}, 32'h0, "R10 cleared");

    // R9 collision of edge and clear
    setPin(32'h108);
    idle(1);
    wr(A_EVT, lb(3));
    rd(A_EVT, lb(3), "R9 edge wins");
    wr(A_EVT, lb(3));
    rd(A_EVT, 0, "R8 clear after");

    // R11 unmapped offsets
    wr(5'h1C, 32'hFFFF_FFFF);
    wr(5'h01, 32'h0);
    rd(5'h1C, 0, "R11 read 0x1C");
    rd(5'h02, 0, "R11 read misaligned");
    rd(A_DIR, lb(0) | lb(5), "R11 dir untouched");
    rd(A_ODR, lb(0) | lb(5), "R11 odr untouched");

    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule